// File: doc/BRIEF.md
# Converter Code Register Controller

This block holds the digital state behind a single-channel voltage-output converter. A serial front end delivers a complete 24-bit frame as an 8-bit command and a 16-bit data word, with a one-cycle strobe when chip select rises. The block decodes that frame into two data stages and a small configuration word. The staging register collects written codes. The output register drives the converter code. Depending on the command and the configuration, a write lands in one or both stages.

Three level inputs act beside the command path. The load input copies the staging register into the output register. The clear input returns every register to its power-up state. The mid-scale select input picks that power-up code. The block also reports the power-down state: a floating output or a resistive termination to ground. Read commands return a register value to the serial shifter, and that value leaves the device in the next transaction.

All inputs are taken as synchronous to `clk`, so any resynchronisation happens upstream. Only channel 0 exists. A frame addressed to any other channel does nothing.

Top module: `dacreg_ctrl`

## Requirements
- R1: After reset, the staging and output registers hold the power-up code, both power-down outputs are low, and the configuration word reads 0x0004 (block mode on, no power-down).
- R2: The plain write (command bits [7:3] = 00001, bits [2:0] = channel, 0x08 for channel 0) loads only the staging register while block mode is on. While block mode is off, it loads both registers on the clock edge that accepts the frame.
- R3: The immediate write 0x10 (channel in bits [2:0]) and the broadcast write 0x20 (bits [2:0] ignored) load both registers whatever the block mode.
- R4: A plain write, immediate write or read whose channel field is not 000 changes no register and produces no read-back pulse.
- R5: The software load 0x18 with data bit 0 set copies the staging register into the output register. With data bit 0 clear, it has no effect.
- R6: While `ld_n` is low, the output register takes the staging register's next value on every edge, so a write accepted in that cycle shows at `dac_code` on the same edge.
- R7: The mode command 0x28 sets block mode to data bit 0 (1 = block, 0 = write-through).
- R8: The power-down command 0x30 selects the floating output with data bit 8 and termination with data bit 0. When both are set, termination applies alone. Writing both bits as 0 leaves power-down. The data registers and commands keep working while powered down.
- R9: `clr_n` low, or the clear command 0x01, returns both data registers to the power-up code (0x0000 with `mid_sel` low, 0x8000 with it high) and the configuration to its reset value. This has priority over any write in the same cycle.
- R10: The reads 0x90 (staging), 0x98 (output) and 0xA0 (configuration word {13'b0, block, term, float}) raise `rb_load` for the one cycle after the accepting edge, with `rb_data` holding the value from before that edge.
- R11: The no-op 0x00 and every unassigned command code change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe: a complete frame is present |
| frm_cmd | input | 8 | Command byte of the frame |
| frm_data | input | 16 | Data word of the frame |
| ld_n | input | 1 | Load level, active low: output follows staging |
| clr_n | input | 1 | Clear level, active low: return to power-up state |
| mid_sel | input | 1 | Power-up code select: 0 = zero, 1 = mid-scale |
| dac_code | output | 16 | Output register, the converter code |
| pd_float | output | 1 | Powered down with the output floating |
| pd_term | output | 1 | Powered down with the output terminated |
| rb_load | output | 1 | Read-back word valid for the serial shifter |
| rb_data | output | 16 | Read-back word |

## Verification
The assertions watch the following on every cycle:
- a clear leaves the power-up code in both data registers;
- a held load keeps the output equal to the staging register;
- a blocked write never moves the output;
- a power-down command with both bits set ends in termination only;
- a configuration read returns the word from before the edge;
- an unassigned frame leaves all state alone.

The bench's scenarios alone can show the rest:
- the ordering effects across frames, such as a staged code surviving until a later software load, or a mode change altering how the next write lands;
- commands still taking effect during power-down;
- the mid-scale choice made by `mid_sel`;
- wrong-channel reads giving no pulse.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

  // Decoded frame events; at most one field is set per frame.
  typedef struct packed {
    logic wr;       // plain write, channel 0
    logic wr_up;    // immediate write, channel 0
    logic wr_all;   // broadcast write
    logic ld_sw;    // software load, channel 0 selected
    logic clr_sw;   // software clear
    logic set_mode; // block / write-through select
    logic pwr_dn;   // power-down select
    logic rd_pre;   // read staging
    logic rd_out;   // read output
    logic rd_cfg;   // read configuration
  } dec_t;

  localparam logic [4:0] OP_WR    = 5'b00001;
  localparam logic [4:0] OP_WRUP  = 5'b00010;
  localparam logic [4:0] OP_WRALL = 5'b00100;
  localparam logic [4:0] OP_RDPRE = 5'b10010;
  localparam logic [4:0] OP_RDOUT = 5'b10011;
  localparam logic [7:0] CMD_CLR  = 8'h01;
  localparam logic [7:0] CMD_LD   = 8'h18;
  localparam logic [7:0] CMD_MODE = 8'h28;
  localparam logic [7:0] CMD_PD   = 8'h30;
  localparam logic [7:0] CMD_RDCF = 8'hA0;

  // Map a command byte and channel-0 mask bit to events.
  function automatic dec_t decode(input logic [7:0] cmd, input logic mask0);
    dec_t e;
    logic ch0;
    e   = '0;
    ch0 = (cmd[2:0] == 3'b000);
    case (cmd[7:3])
      OP_WR:    e.wr     = ch0;
      OP_WRUP:  e.wr_up  = ch0;
      OP_WRALL: e.wr_all = 1'b1;
      OP_RDPRE: e.rd_pre = ch0;
      OP_RDOUT: e.rd_out = ch0;
      default: ;
    endcase
    case (cmd)
      CMD_CLR:  e.clr_sw   = 1'b1;
      CMD_LD:   e.ld_sw    = mask0;
      CMD_MODE: e.set_mode = 1'b1;
      CMD_PD:   e.pwr_dn   = 1'b1;
      CMD_RDCF: e.rd_cfg   = 1'b1;
      default: ;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             frm_valid,
  input  logic [CMD_W-1:0] frm_cmd,
  input  logic             mask0,
  output dec_t             ev
);
  always_comb begin
    ev = '0;
    if (frm_valid) ev = decode(frm_cmd[7:0], mask0);
  end
endmodule

// File: rtl/dacreg_cfg.sv
module dacreg_cfg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_any,
  input  logic          set_mode,
  input  logic          pwr_dn,
  input  logic [DW-1:0] data,
  output logic          blk,
  output logic          term,
  output logic          flt
);
  localparam int HB = DW / 2;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_any) begin
      blk  <= 1'b1;
      term <= 1'b0;
      flt  <= 1'b0;
    end else begin
      if (set_mode) blk <= data[0];
      if (pwr_dn) begin
        term <= data[0];
        flt  <= data[HB] & ~data[0];
      end
    end
  end

  // R8: both selects set leaves termination only
  a_r8_term_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !clr_any && data[0] && data[HB]) |=> (term && !flt));

  // R7: mode command takes data bit 0
  a_r7_mode_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !clr_any) |=> (blk == $past(data[0])));
endmodule

// File: rtl/dacreg_data.sv
module dacreg_data #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_any,
  input  logic          mid_sel,
  input  logic          ld_pin,
  input  logic          ld_sw,
  input  logic          wr_pre,
  input  logic          wr_out,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] pre_q,
  output logic [DW-1:0] out_q
);
  function automatic logic [DW-1:0] pwrup_code(input logic mid);
    return mid ? (DW'(1) << (DW - 1)) : '0;
  endfunction

  logic [DW-1:0] pre_n;
  logic          ld_any;

  assign pre_n  = wr_pre ? data : pre_q;
  assign ld_any = ld_pin | ld_sw;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_any) begin
      pre_q <= pwrup_code(mid_sel);
      out_q <= pwrup_code(mid_sel);
    end else begin
      pre_q <= pre_n;
      if (ld_any)      out_q <= pre_n;
      else if (wr_out) out_q <= data;
    end
  end

  // R9: clear lands on the power-up code
  a_r9_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (out_q == pwrup_code($past(mid_sel)) && pre_q == out_q));

  // R6: held load keeps output equal to staging
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pin && !clr_any) |=> (out_q == pre_q));

  // R2: a staging-only write does not move the output
  a_r2_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pre && !wr_out && !ld_any && !clr_any) |=> $stable(out_q));
endmodule

// File: rtl/dacreg_rdbk.sv
module dacreg_rdbk #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pre,
  input  logic          rd_out,
  input  logic          rd_cfg,
  input  logic [DW-1:0] pre_q,
  input  logic [DW-1:0] out_q,
  input  logic [DW-1:0] cfg_word,
  output logic          rb_load,
  output logic [DW-1:0] rb_data
);
  logic          rd_any;
  logic [DW-1:0] sel;

  assign rd_any = rd_pre | rd_out | rd_cfg;

  always_comb begin
    sel = cfg_word;
    if (rd_pre)      sel = pre_q;
    else if (rd_out) sel = out_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_load <= 1'b0;
      rb_data <= '0;
    end else begin
      rb_load <= rd_any;
      if (rd_any) rb_data <= sel;
    end
  end

  // R10: configuration read returns the word held before the edge
  a_r10_cfg_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg |=> (rb_load && rb_data == $past(cfg_word)));
endmodule

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
  import dacreg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [CMD_W-1:0] frm_cmd,
  input  logic [DW-1:0]    frm_data,
  input  logic             ld_n,
  input  logic             clr_n,
  input  logic             mid_sel,
  output logic [DW-1:0]    dac_code,
  output logic             pd_float,
  output logic             pd_term,
  output logic             rb_load,
  output logic [DW-1:0]    rb_data
);
  dec_t          ev;
  logic          blk, term, flt;
  logic          clr_any, wr_pre, wr_out, unk_frame;
  logic [DW-1:0] pre_q, out_q, cfg_word;

  dacreg_decode #(.CMD_W(CMD_W)) u_dec (
    .frm_valid(frm_valid), .frm_cmd(frm_cmd), .mask0(frm_data[0]), .ev(ev)
  );

  assign clr_any   = ~clr_n | ev.clr_sw;
  assign wr_pre    = ev.wr | ev.wr_up | ev.wr_all;
  assign wr_out    = (ev.wr & ~blk) | ev.wr_up | ev.wr_all;
  assign unk_frame = frm_valid && (ev == '0);
  assign cfg_word  = {{(DW-3){1'b0}}, blk, term, flt};

  dacreg_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr_any(clr_any), .set_mode(ev.set_mode),
    .pwr_dn(ev.pwr_dn), .data(frm_data), .blk(blk), .term(term), .flt(flt)
  );

  dacreg_data #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .clr_any(clr_any), .mid_sel(mid_sel),
    .ld_pin(~ld_n), .ld_sw(ev.ld_sw), .wr_pre(wr_pre), .wr_out(wr_out),
    .data(frm_data), .pre_q(pre_q), .out_q(out_q)
  );

  dacreg_rdbk #(.DW(DW)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .rd_pre(ev.rd_pre), .rd_out(ev.rd_out),
    .rd_cfg(ev.rd_cfg), .pre_q(pre_q), .out_q(out_q), .cfg_word(cfg_word),
    .rb_load(rb_load), .rb_data(rb_data)
  );

  assign dac_code = out_q;
  assign pd_float = flt;
  assign pd_term  = term;

  // R11: an unassigned frame leaves every register alone
  a_r11_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (unk_frame && clr_n && ld_n) |=> ($stable(out_q) && $stable(pre_q) && $stable(cfg_word)));

  // R8: the two power-down outputs are never both high
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_float && pd_term));
endmodule

// File: tb/dacreg_ctrl_test.sv
module dacreg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_n, frm_valid, ld_n, clr_n, mid_sel;
  logic [7:0]  frm_cmd;
  logic [15:0] frm_data;
  logic [15:0] dac_code, rb_data;
  logic        pd_float, pd_term, rb_load;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacreg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
    .frm_data(frm_data), .ld_n(ld_n), .clr_n(clr_n), .mid_sel(mid_sel),
    .dac_code(dac_code), .pd_float(pd_float), .pd_term(pd_term),
    .rb_load(rb_load), .rb_data(rb_data)
  );

  // {cmd, data, expected code, expected staging, expected config[2:0]}
  localparam logic [58:0] VEC [NV] = '{
    {8'h08, 16'h1234, 16'h0000, 16'h1234, 3'd4},
    {8'h18, 16'h0001, 16'h1234, 16'h1234, 3'd4},
    {8'h08, 16'h5555, 16'h1234, 16'h5555, 3'd4},
    {8'h18, 16'h0000, 16'h1234, 16'h5555, 3'd4},
    {8'h28, 16'h0000, 16'h1234, 16'h5555, 3'd0},
    {8'h08, 16'hAAAA, 16'hAAAA, 16'hAAAA, 3'd0},
    {8'h09, 16'h1111, 16'hAAAA, 16'hAAAA, 3'd0},
    {8'h28, 16'h0001, 16'hAAAA, 16'hAAAA, 3'd4},
    {8'h10, 16'h2222, 16'h2222, 16'h2222, 3'd4},
    {8'h11, 16'h3333, 16'h2222, 16'h2222, 3'd4},
    {8'h27, 16'h4444, 16'h4444, 16'h4444, 3'd4},
    {8'h30, 16'h0100, 16'h4444, 16'h4444, 3'd5},
    {8'h30, 16'h0101, 16'h4444, 16'h4444, 3'd6},
    {8'h08, 16'h7777, 16'h4444, 16'h7777, 3'd6},
    {8'h18, 16'h0001, 16'h7777, 16'h7777, 3'd6},
    {8'h30, 16'h0000, 16'h7777, 16'h7777, 3'd4},
    {8'h00, 16'hFFFF, 16'h7777, 16'h7777, 3'd4},
    {8'h3F, 16'hFFFF, 16'h7777, 16'h7777, 3'd4},
    {8'h28, 16'h0000, 16'h7777, 16'h7777, 3'd0},
    {8'h01, 16'h0000, 16'h0000, 16'h0000, 3'd4}
  };
  string TAGS [NV] = '{"R2", "R5", "R2", "R5", "R7", "R2", "R4", "R7", "R3", "R4",
                       "R3", "R8", "R8", "R8", "R8", "R8", "R11", "R11", "R7", "R9"};

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [15:0] d);
    @(negedge clk);
    frm_cmd = c; frm_data = d; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] c, input logic [15:0] exp, input string tag);
    send(c, 16'h0000);
    chk(rb_load === 1'b1, tag, {15'b0, rb_load}, 16'h0001);
    chk(rb_data === exp, tag, rb_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_cmd = '0; frm_data = '0;
    ld_n = 1'b1; clr_n = 1'b1; mid_sel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(dac_code === 16'h0000, "R1", dac_code, 16'h0000);
    chk({pd_float, pd_term} === 2'b00, "R1", {14'b0, pd_float, pd_term}, 16'h0000);
    read_chk(8'hA0, 16'h0004, "R1");
    read_chk(8'h90, 16'h0000, "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  c;
      logic [15:0] d, ec, ep;
      logic [2:0]  ecf;
      {c, d, ec, ep, ecf} = VEC[i];
      send(c, d);
      chk(dac_code === ec, TAGS[i], dac_code, ec);
      chk(pd_float === ecf[0] && pd_term === ecf[1], TAGS[i],
          {14'b0, pd_term, pd_float}, {14'b0, ecf[1], ecf[0]});
      read_chk(8'hA0, {13'b0, ecf}, TAGS[i]);
      read_chk(8'h90, ep, TAGS[i]);
    end

    // R4: read with nonzero channel gives no pulse
    send(8'h91, 16'h0000);
    chk(rb_load === 1'b0, "R4", {15'b0, rb_load}, 16'h0000);

    // R6: held load, block mode on, write shows on the same edge
    @(negedge clk); ld_n = 1'b0;
    send(8'h08, 16'h1357);
    chk(dac_code === 16'h1357, "R6", dac_code, 16'h1357);
    @(negedge clk); ld_n = 1'b1;

    // R9: clear pin with mid-scale select
    mid_sel = 1'b1;
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
    chk(dac_code === 16'h8000, "R9", dac_code, 16'h8000);
    read_chk(8'h90, 16'h8000, "R9");

    // R9: clear beats a write in the same cycle
    @(negedge clk);
    clr_n = 1'b0; frm_cmd = 8'h10; frm_data = 16'h4321; frm_valid = 1'b1;
    @(negedge clk);
    clr_n = 1'b1; frm_valid = 1'b0;
    chk(dac_code === 16'h8000, "R9", dac_code, 16'h8000);

    // R10: output read, and staging after a block-mode write
    send(8'h08, 16'h0F0F);
    read_chk(8'h98, 16'h8000, "R10");
    read_chk(8'h90, 16'h0F0F, "R10");
    @(negedge clk);
    chk(rb_load === 1'b0, "R10", {15'b0, rb_load}, 16'h0000);

    finish_run();
  end
endmodule